// File: doc/BRIEF.md
# Strobe-Driven Single-Bit FIFO

This block is a sixteen-entry, one-bit-wide first-in-first-out store. Its writer and its reader do not share a clock. The writer offers a bit by raising an input strobe. The reader takes a bit by dropping an output strobe. Two ready flags tell each side whether it may act: one shows there is room for another bit, and the other shows a valid bit is waiting. Both strobes are sampled and edge-detected in a single system clock domain. This lets the block act as an elastic buffer between a serial source and a serial sink that run at slightly different rates. The two strobes may also be driven by one shared signal, so a bit enters on each rising edge and leaves on each falling edge.

Occupancy is tracked by a three-state controller:
- `ST_EMPTY` goes to `ST_PARTIAL` on an accepted write.
- `ST_PARTIAL` goes to `ST_FULL` on a lone write that brings the count to the depth.
- `ST_PARTIAL` goes to `ST_EMPTY` on a lone read of the last bit.
- `ST_FULL` goes to `ST_PARTIAL` on an accepted read.
- Every other combination keeps the current state.

The ready flags are decoded from the state. The data output shows the oldest stored bit. When the store is empty, it shows the last bit that was removed.

Top module: `strobe_bit_fifo`

## Requirements
- R1: A synchronous active-high reset empties the store and sets `in_ready` to 1, `out_ready` to 0 and `dout` to 0.
- R2: A 0-to-1 transition on `shift_in` appends `din` at the tail when there is room. A 1-to-0 transition or a steady level on `shift_in` stores nothing.
- R3: A 1-to-0 transition on `shift_out` removes the head bit when one is present. A 0-to-1 transition or a steady level on `shift_out` removes nothing.
- R4: Bits leave in exactly the order they entered, and up to 16 bits can be held.
- R5: `in_ready` is 0 exactly when 16 bits are stored.
- R6: `out_ready` is 1 exactly when at least one bit is stored, and it can only rise after a write edge.
- R7: A write edge while `in_ready` is 0 is ignored, and the stored contents and their order are unchanged.
- R8: A read edge while `out_ready` is 0 is ignored, and `dout` keeps the last bit that was removed.
- R9: A write edge and a read edge detected in the same clock cycle, with the store neither empty nor full, leave the occupancy unchanged and preserve the order.
- R10: While `out_ready` is 1, `dout` equals the oldest stored bit.
- R11: A strobe edge takes effect at the second rising clock edge after the strobe changes. Each strobe level must be held for at least two clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both strobes |
| rst | input | 1 | Synchronous reset, active high |
| shift_in | input | 1 | Write strobe; a rising edge stores `din` |
| din | input | 1 | Serial data bit to store |
| shift_out | input | 1 | Read strobe; a falling edge removes the head bit |
| dout | output | 1 | Head bit, or the last removed bit when empty |
| in_ready | output | 1 | High while a further bit can be accepted |
| out_ready | output | 1 | High while a valid bit is presented |

## Verification
The store is exercised with five patterns:
- A short irregular bit pattern written and then read, which exposes ordering and head-selection errors.
- A fill to exactly sixteen bits followed by extra writes, which separates a correct full limit from overwrite or off-by-one faults.
- A complete drain followed by extra reads, which shows whether the output holds the last removed bit.
- One signal driving both strobes, which distinguishes acting only on the rising or falling edge from acting on any level change.
- Write and read edges in the same cycle at middle occupancy and when empty, which checks that the count is kept and that an empty-store read is refused while the write is taken.

// File: rtl/sbf_pkg.sv
package sbf_pkg;

    // Occupancy states of the controller
    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } occ_state_t;

endpackage

// File: rtl/sbf_edge.sv
// Samples an asynchronous strobe and emits a one-cycle pulse on the chosen edge.
module sbf_edge #(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic pulse
);
    logic smp_q;
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q  <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            smp_q  <= strobe;
            prev_q <= smp_q;
        end
    end

    generate
        if (RISING) begin : g_rise
            assign pulse = smp_q & ~prev_q;
        end else begin : g_fall
            assign pulse = ~smp_q & prev_q;
        end
    endgenerate

endmodule

// File: rtl/sbf_store.sv
// Circular bit store with head and tail pointers plus a last-removed register.
module sbf_store #(
    parameter int DEPTH = 16,
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic rd_en,
    input  logic din,
    output logic head_bit,
    output logic last_bit
);
    localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

    logic [DEPTH-1:0] cells_q;
    logic [PW-1:0]    wp_q;
    logic [PW-1:0]    rp_q;
    logic             last_q;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            cells_q <= '0;
            wp_q    <= '0;
            rp_q    <= '0;
            last_q  <= 1'b0;
        end else begin
            if (wr_en) begin
                cells_q[wp_q] <= din;
                wp_q          <= step(wp_q);
            end
            if (rd_en) begin
                last_q <= cells_q[rp_q];
                rp_q   <= step(rp_q);
            end
        end
    end

    assign head_bit = cells_q[rp_q];
    assign last_bit = last_q;

endmodule

// File: rtl/sbf_ctrl.sv
// Occupancy state machine: accepts or refuses edges and drives the ready flags.
module sbf_ctrl
    import sbf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_req,
    input  logic rd_req,
    output logic wr_en,
    output logic rd_en,
    output logic in_rdy,
    output logic out_rdy
);
    localparam logic [CW-1:0] TOP_M1 = CW'(DEPTH - 1);
    localparam logic [CW-1:0] ONE    = CW'(1);

    occ_state_t     state_q, state_nxt;
    logic [CW-1:0]  cnt_q, cnt_nxt;

    assign wr_en = wr_req & in_rdy;
    assign rd_en = rd_req & out_rdy;

    always_comb begin
        unique case ({wr_en, rd_en})
            2'b10:   cnt_nxt = cnt_q + ONE;
            2'b01:   cnt_nxt = cnt_q - ONE;
            default: cnt_nxt = cnt_q;
        endcase
    end

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (wr_en) state_nxt = ST_PARTIAL;
            end
            ST_PARTIAL: begin
                if (wr_en && !rd_en && cnt_q == TOP_M1)
                    state_nxt = ST_FULL;
                else if (rd_en && !wr_en && cnt_q == ONE)
                    state_nxt = ST_EMPTY;
            end
            ST_FULL: begin
                if (rd_en) state_nxt = ST_PARTIAL;
            end
            default: state_nxt = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nxt;
            cnt_q   <= cnt_nxt;
        end
    end

    // Flag outputs
    always_comb begin
        in_rdy  = 1'b1;
        out_rdy = 1'b0;
        unique case (state_q)
            ST_EMPTY:   begin in_rdy = 1'b1; out_rdy = 1'b0; end
            ST_PARTIAL: begin in_rdy = 1'b1; out_rdy = 1'b1; end
            ST_FULL:    begin in_rdy = 1'b0; out_rdy = 1'b1; end
            default:    begin in_rdy = 1'b1; out_rdy = 1'b0; end
        endcase
    end

endmodule

// File: rtl/strobe_bit_fifo.sv
module strobe_bit_fifo #(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic shift_in,
    input  logic din,
    input  logic shift_out,
    output logic dout,
    output logic in_ready,
    output logic out_ready
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic wr_pulse;
    logic rd_pulse;
    logic wr_en;
    logic rd_en;
    logic head_bit;
    logic last_bit;

    sbf_edge #(.RISING(1'b1)) u_in_edge (
        .clk(clk), .rst(rst), .strobe(shift_in), .pulse(wr_pulse)
    );

    sbf_edge #(.RISING(1'b0)) u_out_edge (
        .clk(clk), .rst(rst), .strobe(shift_out), .pulse(rd_pulse)
    );

    sbf_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
        .clk(clk), .rst(rst),
        .wr_req(wr_pulse), .rd_req(rd_pulse),
        .wr_en(wr_en), .rd_en(rd_en),
        .in_rdy(in_ready), .out_rdy(out_ready)
    );

    sbf_store #(.DEPTH(DEPTH), .PW(PW)) u_store (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .rd_en(rd_en), .din(din),
        .head_bit(head_bit), .last_bit(last_bit)
    );

    assign dout = out_ready ? head_bit : last_bit;

endmodule

// File: rtl/sbf_chk.sv
module sbf_chk (
    input logic clk,
    input logic rst,
    input logic in_ready,
    input logic out_ready,
    input logic dout,
    input logic wr_pulse,
    input logic rd_pulse
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (in_ready && !out_ready && !dout));

    // R5
    flags_consistent_chk: assert property (@(posedge clk) disable iff (rst)
        (in_ready || out_ready));

    // R6
    ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_ready) |-> $past(wr_pulse));

    // R7
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_ready && !rd_pulse) |=> !in_ready);

    // R8
    empty_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !out_ready |=> (out_ready || $stable(dout)));

    // R9
    both_edges_chk: assert property (@(posedge clk) disable iff (rst)
        (in_ready && out_ready && wr_pulse && rd_pulse) |=> (in_ready && out_ready));

endmodule

bind strobe_bit_fifo sbf_chk u_chk (
    .clk(clk), .rst(rst), .in_ready(in_ready), .out_ready(out_ready),
    .dout(dout), .wr_pulse(wr_pulse), .rd_pulse(rd_pulse)
);

// File: tb/strobe_bit_fifo_tb.sv
`timescale 1ns/1ps
module strobe_bit_fifo_tb;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic shift_in = 1'b0;
    logic din = 1'b0;
    logic shift_out = 1'b0;
    logic dout, in_ready, out_ready;

    int checks = 0;
    int errors = 0;
    bit mon_en = 1'b0;
    bit model_q[$];
    bit model_last = 1'b0;

    always #2 clk = ~clk;

    strobe_bit_fifo #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .shift_in(shift_in), .din(din),
        .shift_out(shift_out), .dout(dout),
        .in_ready(in_ready), .out_ready(out_ready)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Monitor: compares flags and head bit with the scoreboard at each falling clock
    always @(negedge clk) begin
        if (mon_en) begin
            check(out_ready == (model_q.size() > 0), "R6 out_ready", out_ready, model_q.size() > 0);
            check(in_ready == (model_q.size() < DEPTH), "R5 in_ready", in_ready, model_q.size() < DEPTH);
            if (model_q.size() > 0)
                check(dout == model_q[0], "R10 R4 head bit", dout, model_q[0]);
            else
                check(dout == model_last, "R8 held bit", dout, model_last);
        end
    end

    // Driver: changes strobe levels at a falling clock and updates the scoreboard
    // at the second rising edge, where the design acts (R11).
    task automatic drive(input bit ni, input bit no, input bit d);
        bit rise, fall, wr_ok, rd_ok;
        rise = ni && !shift_in;
        fall = !no && shift_out;
        shift_in = ni;
        shift_out = no;
        din = d;
        @(posedge clk);
        @(posedge clk);
        #1;
        wr_ok = rise && (model_q.size() < DEPTH);
        rd_ok = fall && (model_q.size() > 0);
        if (rd_ok) model_last = model_q.pop_front();
        if (wr_ok) model_q.push_back(d);
        @(negedge clk);
    endtask

    task automatic wr(input bit d);
        drive(1'b1, shift_out, d);
        drive(1'b0, shift_out, d);
    endtask

    task automatic rd();
        drive(shift_in, 1'b1, din);
        drive(shift_in, 1'b0, din);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
        check(out_ready == 1'b0, "R1 out_ready", out_ready, 0);
        check(dout == 1'b0, "R1 dout", dout, 0);

        // R11 latency: no effect after one rising edge, effect after two
        shift_in = 1'b1;
        din = 1'b1;
        @(negedge clk);
        check(out_ready == 1'b0, "R11 one edge", out_ready, 0);
        @(negedge clk);
        check(out_ready == 1'b1, "R11 two edges", out_ready, 1);
        check(dout == 1'b1, "R2 stored bit", dout, 1);
        model_q.push_back(1'b1);
        mon_en = 1'b1;
        drive(1'b0, 1'b0, 1'b0);   // falling shift_in stores nothing (R2)
        rd();                      // rising then falling shift_out (R3)
        check(out_ready == 1'b0, "R3 single read", out_ready, 0);

        // Irregular pattern, R4
        wr(1); wr(0); wr(1); wr(1); wr(0);
        repeat (5) rd();

        // Fill to the limit, then overfill (R5, R7)
        for (int i = 0; i < DEPTH; i++) wr((i % 3) == 0);
        check(in_ready == 1'b0, "R5 full", in_ready, 0);
        wr(0); wr(1); wr(0);
        check(model_q.size() == DEPTH, "R7 model size", model_q.size(), DEPTH);
        for (int i = 0; i < DEPTH; i++) rd();
        check(out_ready == 1'b0, "R8 drained", out_ready, 0);
        rd(); rd();
        check(dout == model_last, "R8 dout after empty reads", dout, model_last);

        // Shared strobe: rising writes, falling reads
        wr(1); wr(0); wr(0); wr(1);
        for (int i = 0; i < 6; i++) begin
            drive(1'b1, 1'b1, (i % 2) == 1);
            drive(1'b0, 1'b0, 1'b0);
        end
        check(out_ready && in_ready, "R9 tied strobes occupancy", {out_ready, in_ready}, 3);

        // Same-cycle write and read edges at middle occupancy (R9)
        drive(1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 6; i++) begin
            drive(1'b1, 1'b0, (i % 3) != 1);
            drive(1'b0, 1'b1, 1'b0);
        end
        check(model_q.size() == 4, "R9 model size", model_q.size(), 4);
        repeat (4) rd();
        check(out_ready == 1'b0, "R9 drained after four", out_ready, 0);

        // Same-cycle edges when empty: write taken, read refused (R8, R2)
        drive(1'b0, 1'b1, 1'b1);
        drive(1'b1, 1'b0, 1'b1);
        check(out_ready == 1'b1, "R8 empty read refused", out_ready, 1);
        check(dout == 1'b1, "R2 write with read", dout, 1);
        drive(1'b0, 1'b1, 1'b0);
        drive(1'b0, 1'b0, 1'b0);
        check(out_ready == 1'b0, "R3 final read", out_ready, 0);

        mon_en = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule